// File: doc/BRIEF.md
# Per-Agent Bus Request Controller

This block is the request side of one processor agent on a shared bus. The agent's own logic presents two kinds of pending work: a core access, and a DMA access that carries a high or normal priority attribute. The block turns that work into a bus request. Alongside the request it raises one of two priority flags, which the rest of the cluster sees as the core-priority line and the DMA-priority line. The block takes no part in the arbitration decision itself. That decision, the data moves and the DMA engine all lie outside it.

The block also watches the same two cluster lines as driven by the other agents. When higher-priority traffic from elsewhere appears, it withdraws its own request. If a transaction of its own is still in flight, it first lets that transaction finish. It requests again as soon as the competing lines fall. A core access always takes precedence over DMA work inside the agent. The two priority flags are never raised together.

The controller is a five-state machine. **IDLE**: nothing is requested. **CORE**: a core access is requested. **DMA**: a DMA access is requested. **YIELD**: the agent must give way but is finishing its current transaction. **BACKOFF**: the request is withdrawn until the competing lines clear.

The transitions are as follows.
- IDLE→CORE when a core access is pending.
- IDLE→DMA when a DMA access is pending and the DMA access is not blocked.
- CORE→IDLE on the done strobe.
- DMA→CORE when a core access is pending and no transaction is in flight.
- DMA→IDLE when the DMA work is withdrawn.
- DMA→YIELD when the DMA access is blocked mid-transaction.
- DMA→BACKOFF when the DMA access is blocked and no transaction is in flight, or the done strobe arrives in that cycle.
- YIELD→BACKOFF on the done strobe.
- BACKOFF→CORE when a core access is pending.
- BACKOFF→IDLE when the DMA work is withdrawn.
- BACKOFF→DMA once the DMA access is no longer blocked.

A DMA access is blocked when another agent drives core priority. A normal-priority DMA access is also blocked when another agent drives DMA priority.

Top module: `agent_req_ctrl`

## Requirements
- R1: From IDLE with `core_req_i` high, the cycle after the edge shows `bus_req_o`=1, `core_pri_o`=1, `dma_pri_o`=0.
- R2: A DMA access with `dma_hi_i`=1 that is not blocked shows `bus_req_o`=1 and `dma_pri_o`=1, with `core_pri_o`=0.
- R3: A DMA access with `dma_hi_i`=0 that is not blocked shows only `bus_req_o`=1.
- R4: `core_pri_o` and `dma_pri_o` are never 1 together, and either flag at 1 implies `bus_req_o`=1.
- R5: While requesting for DMA only with no transaction in flight, `oth_core_pri_i`=1 drops `bus_req_o` and `dma_pri_o` on the next edge.
- R6: When the agent must yield with `xfer_busy_i`=1, its outputs hold until `xfer_done_i` pulses. The request and the flag drop on that edge.
- R7: In CORE, a pulse on `xfer_done_i` clears `bus_req_o` and `core_pri_o` on that edge.
- R8: A normal-priority DMA requester seeing `oth_dma_pri_i`=1 drops `bus_req_o`. A high-priority DMA requester is unaffected by `oth_dma_pri_i`.
- R9: After backing off, the request returns on the first edge at which the blocking lines are sampled inactive.
- R10: When core and DMA work are pending together from IDLE, the core access is requested first.
- R11: While `rst_n` is low, all three outputs are 0.
- R12: Withdrawing `dma_req_i` in DMA drops `bus_req_o` and `dma_pri_o` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_req_i | input | 1 | Core access pending |
| dma_req_i | input | 1 | DMA access pending |
| dma_hi_i | input | 1 | Pending DMA access is high priority |
| xfer_busy_i | input | 1 | A transaction owned by this agent is in flight |
| xfer_done_i | input | 1 | One-cycle strobe marking the end of this agent's transaction |
| oth_core_pri_i | input | 1 | Core-priority line as driven by other agents |
| oth_dma_pri_i | input | 1 | DMA-priority line as driven by other agents |
| bus_req_o | output | 1 | Bus request |
| core_pri_o | output | 1 | Core-priority flag |
| dma_pri_o | output | 1 | DMA-priority flag |

## Verification
Every output is a register loaded from the next-state decode, so every result is due one edge after the inputs that cause it are sampled. This holds for raising a request, backing off, yielding on the done strobe and re-requesting. The bench changes inputs just after a falling edge and lets one rising edge pass. It then compares all three outputs with its own model at the following falling edge, before any input moves again. Directed sequences cover the following corners:
- yield in flight
- the blocking lines clearing
- core and DMA work pending together
- DMA work withdrawn

A seeded random run then covers mixed traffic.

// File: rtl/arq_pkg.sv
package arq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CORE,
        ST_DMA,
        ST_YIELD,
        ST_BACKOFF
    } arq_state_t;

    typedef struct packed {
        logic req;
        logic core_pri;
        logic dma_pri;
    } arq_out_t;

    localparam arq_out_t ARQ_OFF = '{req: 1'b0, core_pri: 1'b0, dma_pri: 1'b0};

endpackage

// File: rtl/arq_block.sv
module arq_block (
    input  logic dma_hi_i,
    input  logic oth_core_pri_i,
    input  logic oth_dma_pri_i,
    output logic dma_blocked_o
);
    // Core traffic elsewhere blocks every DMA request.
    // DMA-priority traffic elsewhere blocks only a normal-priority request.
    always_comb begin
        dma_blocked_o = oth_core_pri_i || (!dma_hi_i && oth_dma_pri_i);
    end
endmodule

// File: rtl/arq_fsm.sv
module arq_fsm
    import arq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       core_req_i,
    input  logic       dma_req_i,
    input  logic       dma_blocked_i,
    input  logic       xfer_busy_i,
    input  logic       xfer_done_i,
    output arq_state_t state_o,
    output arq_state_t nxt_o
);
    arq_state_t state_q, nxt;

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (core_req_i)                        nxt = ST_CORE;
                else if (dma_req_i && !dma_blocked_i)  nxt = ST_DMA;
            end
            ST_CORE: begin
                if (xfer_done_i)                       nxt = ST_IDLE;
            end
            ST_DMA: begin
                if (core_req_i && !xfer_busy_i)        nxt = ST_CORE;
                else if (!dma_req_i)                   nxt = ST_IDLE;
                else if (dma_blocked_i)
                    nxt = (xfer_busy_i && !xfer_done_i) ? ST_YIELD : ST_BACKOFF;
            end
            ST_YIELD: begin
                if (xfer_done_i)                       nxt = ST_BACKOFF;
            end
            ST_BACKOFF: begin
                if (core_req_i)                        nxt = ST_CORE;
                else if (!dma_req_i)                   nxt = ST_IDLE;
                else if (!dma_blocked_i)               nxt = ST_DMA;
            end
            default:                                   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    assign state_o = state_q;
    assign nxt_o   = nxt;

    // R6
    yield_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_YIELD && !xfer_done_i) |=> (state_q == ST_YIELD));
endmodule

// File: rtl/arq_outreg.sv
module arq_outreg
    import arq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  arq_state_t nxt_i,
    input  logic       dma_hi_i,
    output arq_out_t   out_o
);
    arq_out_t out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= ARQ_OFF;
        end else begin
            unique case (nxt_i)
                ST_CORE:           out_q <= '{req: 1'b1, core_pri: 1'b1, dma_pri: 1'b0};
                ST_DMA, ST_YIELD:  out_q <= '{req: 1'b1, core_pri: 1'b0, dma_pri: dma_hi_i};
                default:           out_q <= ARQ_OFF;
            endcase
        end
    end

    assign out_o = out_q;

    // R4
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_q.core_pri && out_q.dma_pri));

    // R4
    flag_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.core_pri || out_q.dma_pri) |-> out_q.req);
endmodule

// File: rtl/agent_req_ctrl.sv
module agent_req_ctrl
    import arq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic core_req_i,
    input  logic dma_req_i,
    input  logic dma_hi_i,
    input  logic xfer_busy_i,
    input  logic xfer_done_i,
    input  logic oth_core_pri_i,
    input  logic oth_dma_pri_i,
    output logic bus_req_o,
    output logic core_pri_o,
    output logic dma_pri_o
);
    logic       dma_blocked;
    arq_state_t state, nxt;
    arq_out_t   outs;

    arq_block blk_i (
        .dma_hi_i       (dma_hi_i),
        .oth_core_pri_i (oth_core_pri_i),
        .oth_dma_pri_i  (oth_dma_pri_i),
        .dma_blocked_o  (dma_blocked)
    );

    arq_fsm fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .core_req_i    (core_req_i),
        .dma_req_i     (dma_req_i),
        .dma_blocked_i (dma_blocked),
        .xfer_busy_i   (xfer_busy_i),
        .xfer_done_i   (xfer_done_i),
        .state_o       (state),
        .nxt_o         (nxt)
    );

    arq_outreg out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_i    (nxt),
        .dma_hi_i (dma_hi_i),
        .out_o    (outs)
    );

    assign bus_req_o  = outs.req;
    assign core_pri_o = outs.core_pri;
    assign dma_pri_o  = outs.dma_pri;

    // R7
    core_done_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CORE && xfer_done_i) |=> (!core_pri_o && !bus_req_o));

    // R5
    dma_yields_to_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DMA && oth_core_pri_i && !core_req_i && !xfer_busy_i)
            |=> (!bus_req_o && !dma_pri_o));

    // R1
    core_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && core_req_i) |=> (bus_req_o && core_pri_o));
endmodule

// File: tb/agent_req_ctrl_tb_top.sv
module agent_req_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_req = 0, dma_req = 0, dma_hi = 0, busy = 0, done = 0, ocp = 0, odp = 0;
    logic bus_req, core_pri, dma_pri;
    int checks = 0;
    int errors = 0;
    int mode = 0;   // 0 idle 1 core 2 dma 3 yield 4 backoff
    logic e_req, e_cp, e_dp;

    always #4 clk = ~clk;   // 125 MHz

    agent_req_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .core_req_i(core_req), .dma_req_i(dma_req),
        .dma_hi_i(dma_hi), .xfer_busy_i(busy), .xfer_done_i(done),
        .oth_core_pri_i(ocp), .oth_dma_pri_i(odp),
        .bus_req_o(bus_req), .core_pri_o(core_pri), .dma_pri_o(dma_pri)
    );

    function automatic int model_next(int m);
        bit blk = ocp || (!dma_hi && odp);
        case (m)
            0: return core_req ? 1 : ((dma_req && !blk) ? 2 : 0);
            1: return done ? 0 : 1;
            2: begin
                if (core_req && !busy) return 1;
                if (!dma_req) return 0;
                if (blk) return (busy && !done) ? 3 : 4;
                return 2;
            end
            3: return done ? 4 : 3;
            default: begin
                if (core_req) return 1;
                if (!dma_req) return 0;
                return blk ? 4 : 2;
            end
        endcase
    endfunction

    task automatic chk(string tag, logic r, logic c, logic d);
        checks++;
        if (bus_req !== r || core_pri !== c || dma_pri !== d) begin
            errors++;
            $display("FAIL %s req/core/dma actual %b%b%b expected %b%b%b",
                     tag, bus_req, core_pri, dma_pri, r, c, d);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        mode = model_next(mode);
        e_req = (mode == 1 || mode == 2 || mode == 3);
        e_cp  = (mode == 1);
        e_dp  = (mode == 2 || mode == 3) && dma_hi;
        @(negedge clk);
        chk(tag, e_req, e_cp, e_dp);
        done = 0;
    endtask

    task automatic clr();
        core_req = 0; dma_req = 0; dma_hi = 0; busy = 0; done = 0; ocp = 0; odp = 0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        string tg;
        #20;
        @(negedge clk);
        chk("R11", 0, 0, 0);
        rst_n = 1;
        // R1 then R7
        core_req = 1; step("R1");
        chk("R4", bus_req, core_pri, 1'b0);
        core_req = 0; done = 1; step("R7");
        chk("R7", 0, 0, 0);
        // R2, R8 hi unaffected by other DMA line
        dma_req = 1; dma_hi = 1; step("R2");
        chk("R2", 1, 0, 1);
        odp = 1; step("R8");
        chk("R8", 1, 0, 1);
        odp = 0; dma_hi = 0; step("R3");
        chk("R3", 1, 0, 0);
        // R8 normal backs off, R9 returns
        odp = 1; step("R8");
        chk("R8", 0, 0, 0);
        step("R8");
        odp = 0; step("R9");
        chk("R9", 1, 0, 0);
        // R5 other core, no transaction
        dma_hi = 1; step("R2");
        ocp = 1; step("R5");
        chk("R5", 0, 0, 0);
        ocp = 0; step("R9");
        chk("R9", 1, 0, 1);
        // R6 yield while busy
        busy = 1; ocp = 1; step("R6");
        chk("R6", 1, 0, 1);
        step("R6");
        chk("R6", 1, 0, 1);
        done = 1; step("R6");
        chk("R6", 0, 0, 0);
        busy = 0; ocp = 0; step("R9");
        chk("R9", 1, 0, 1);
        // R12 withdraw
        dma_req = 0; step("R12");
        chk("R12", 0, 0, 0);
        // R10 both pending
        core_req = 1; dma_req = 1; dma_hi = 1; step("R10");
        chk("R10", 1, 1, 0);
        core_req = 0; done = 1; step("R7");
        step("R10");
        chk("R10", 1, 0, 1);
        clr(); step("R12");
        // random traffic
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 3000; i++) begin
            core_req = ($urandom % 8) == 0;
            if (($urandom % 10) == 0) dma_req = ~dma_req;
            if (($urandom % 12) == 0) dma_hi = ~dma_hi;
            busy = $urandom % 2;
            done = ($urandom % 5) == 0;
            ocp  = ($urandom % 6) == 0;
            odp  = ($urandom % 4) == 0;
            case (model_next(mode))
                1: tg = "R1";
                2: tg = dma_hi ? "R2" : "R3";
                3: tg = "R6";
                4: tg = "R5";
                default: tg = "R12";
            endcase
            step(tg);
            checks++;
            if (core_pri && dma_pri) begin
                errors++;
                $display("FAIL R4 core/dma actual %b%b expected not 11", core_pri, dma_pri);
            end
        end
        // R11 reset mid-request
        clr(); core_req = 1; step("R1");
        rst_n = 0; #1;
        chk("R11", 0, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule